// File: doc/BRIEF.md
# Multi-Chain JTAG Scan Selector

This block sits behind a standard 1149.1 TAP controller and steers the serial test path between four internal scan chains, a one-cell bypass register and a 32-bit identification register. The controller supplies its current state as a 4-bit code. The block holds the instruction register, a 4-bit chain-number register, and two chains that drive core-side values straight from their shift cells. Chain 0 covers four data bits, four control signals and the address bus, for 40 cells. Chain 1 covers the 32-bit core data bus. Chains 2 and 3 live outside the block. For those two chains the block forwards TDI and the capture, shift and update strobes, and it takes each chain's serial return on an input.

To pick a chain, load the select opcode into the instruction register, then scan the chain number into the chain-number register. Then load the access opcode, and every data-register scan goes through the chosen chain. Chains 0 and 1 have no update latch, so every shift clock changes their parallel outputs. The block therefore asks for the core clock to be held whenever either of them is the selected chain.

The serial path is clocked by TCK and moves one bit on every TCK cycle in a shift state. There is no valid/ready interface and no back-pressure. The TAP state and TDI are plain inputs. TDO and its enable are plain outputs that update on the falling edge of TCK.

Top module: `jtag_chain_sel`

## Requirements
- R1: The instruction register is 4 bits wide and shifts LSB first. Capture-IR loads 4'b0001. After trst_n is asserted the register holds IDCODE (4'hE), and in IDCODE a data scan returns ID_CODE LSB first.
- R2: Opcode 4'hF selects a one-cell bypass register that captures 0, so scanned data comes back delayed by one bit.
- R3: Opcode 4'h2 selects the 4-bit chain-number register, which shifts LSB first. Capture-DR loads the current chain number, and a new number takes effect only at Update-DR. The reset value is 3.
- R4: With opcode 4'h0 and chain 1 selected, Capture-DR loads core_dbus_in. Cell i carries data bit i, bit 0 sits nearest TDI and bit 31 is shifted out first. ch1_dbus_out follows every shift without waiting for Update-DR.
- R5: With opcode 4'h0 and chain 0 selected, the 40 cells run from TDI as core data bits 0 to 3, then control bits 0 to 3, then address bits 31 down to 0. Address bit 0 is shifted out first. The ch0 outputs follow the shift cells.
- R6: With opcode 4'h0 and chain 2 or 3 selected, ext_sel is 2'b01 or 2'b10. ext_capture, ext_shift and ext_update pulse in the matching TAP states. TDO returns ext_so[0] or ext_so[1].
- R7: core_clk_hold is high exactly while the chain number is 0 or 1.
- R8: The TAP state codes are Test-Logic-Reset 4'hF, Run-Test/Idle 4'hC, Capture-DR 4'h6, Shift-DR 4'h2, Exit1-DR 4'h1, Pause-DR 4'h3, Update-DR 4'h5, Capture-IR 4'hE, Shift-IR 4'hA, Exit1-IR 4'h9 and Update-IR 4'hD. TDO and tdo_en update on the falling edge of TCK, and tdo_en is high only after a falling edge in Shift-DR or Shift-IR.
- R9: The unsupported optional opcodes RUNBIST (4'h4), INTEST (4'hC) and USERCODE (4'h8) select the bypass register, and so does every other undefined opcode.
- R10: A chain number from 4 to 15 selects no chain. Under opcode 4'h0 the bypass register is used, ext_sel is 0 and core_clk_hold is low.
- R11: The Test-Logic-Reset state alone, without trst_n, returns the instruction register to IDCODE and the chain number to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tap_state | input | 4 | Current TAP controller state code |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge registered |
| tdo_en | output | 1 | TDO output enable |
| core_dbus_in | input | 32 | Core data bus sampled by chains 0 and 1 |
| core_abus_in | input | 32 | Core address bus sampled by chain 0 |
| core_ctrl_in | input | 4 | Core control signals sampled by chain 0 |
| ch0_dbus_out | output | 4 | Chain 0 data cells |
| ch0_ctrl_out | output | 4 | Chain 0 control cells |
| ch0_abus_out | output | 32 | Chain 0 address cells |
| ch1_dbus_out | output | 32 | Chain 1 data cells |
| core_clk_hold | output | 1 | Request to hold the core clock |
| ext_si | output | 1 | Serial data to external chains 2 and 3 |
| ext_so | input | 2 | Serial returns of chain 2 (bit 0) and chain 3 (bit 1) |
| ext_sel | output | 2 | One-hot select of chain 2 (bit 0) or chain 3 (bit 1) |
| ext_capture | output | 1 | Capture strobe for the selected external chain |
| ext_shift | output | 1 | Shift strobe for the selected external chain |
| ext_update | output | 1 | Update strobe for the selected external chain |

## Verification
The bench drives the chain-number register through a scan that ends in Pause-DR instead of Update-DR, and checks that a new number does not take effect early. The same run catches a design that latches the number at the wrong time. On chain 1 it stops a partial shift in Pause-DR and compares the parallel outputs with the partly shifted pattern, which exposes a hidden update stage or a reversed shift direction. On chain 0 it checks the three field boundaries and the reversed address order bit by bit, so an off-by-one segment or a flipped address order shows up as a mismatch. The bench also covers the unsupported opcodes, an out-of-range chain number, and a reset through the Test-Logic-Reset state without trst_n. A design that decoded these to a live chain, or that asserted the clock hold for them, would return the wrong serial data or a wrong core_clk_hold.

// File: rtl/jsel_pkg.sv
package jsel_pkg;
  // TAP controller state codes as delivered by the controller
  typedef enum logic [3:0] {
    TS_EX2DR   = 4'h0, TS_EX1DR   = 4'h1, TS_SHDR    = 4'h2, TS_PAUSEDR = 4'h3,
    TS_SELIR   = 4'h4, TS_UPDDR   = 4'h5, TS_CAPDR   = 4'h6, TS_SELDR   = 4'h7,
    TS_EX2IR   = 4'h8, TS_EX1IR   = 4'h9, TS_SHIR    = 4'hA, TS_PAUSEIR = 4'hB,
    TS_RTI     = 4'hC, TS_UPDIR   = 4'hD, TS_CAPIR   = 4'hE, TS_TLR     = 4'hF
  } tap_state_e;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_ACCESS  = 4'h0;
  localparam logic [IR_W-1:0] OP_SELECT  = 4'h2;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'hE;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  // data-register path chosen by instruction and chain number
  typedef enum logic [2:0] {
    P_BYPASS, P_IDCODE, P_SELECT, P_CH0, P_CH1, P_EXT
  } dr_path_e;
endpackage

// File: rtl/jsel_scan_chain.sv
// Shift register whose cells are also its parallel outputs (no update latch).
module jsel_scan_chain #(
  parameter int LEN        = 32,
  parameter bit OUT_AT_LSB = 1'b0
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           cap_en,
  input  logic           shift_en,
  input  logic           si,
  input  logic [LEN-1:0] cap_val,
  output logic [LEN-1:0] cells
);
  logic [LEN-1:0] nxt;

  generate
    if (LEN == 1) begin : g_single
      assign nxt = si;
    end else if (OUT_AT_LSB) begin : g_to_lsb
      assign nxt = {si, cells[LEN-1:1]};
    end else begin : g_to_msb
      assign nxt = {cells[LEN-2:0], si};
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       cells <= '0;
    else if (cap_en)   cells <= cap_val;
    else if (shift_en) cells <= nxt;
  end
endmodule

// File: rtl/jsel_shadowed_reg.sv
// Shift stage plus update register; used for the instruction and chain-number registers.
module jsel_shadowed_reg #(
  parameter int           W         = 4,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter bit           CAP_CONST = 1'b0,
  parameter logic [W-1:0] CAP_VAL   = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         sync_rst,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic         upd_en,
  input  logic         si,
  output logic [W-1:0] q,
  output logic         so
);
  logic [W-1:0] cap_src;
  logic [W-1:0] cells;

  generate
    if (CAP_CONST) begin : g_cap_const
      assign cap_src = CAP_VAL;
    end else begin : g_cap_q
      assign cap_src = q;
    end
  endgenerate

  jsel_scan_chain #(.LEN(W), .OUT_AT_LSB(1'b1)) u_sh (
    .tck      (tck),
    .trst_n   (trst_n),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .si       (si),
    .cap_val  (cap_src),
    .cells    (cells)
  );

  assign so = cells[0];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       q <= RST_VAL;
    else if (sync_rst) q <= RST_VAL;
    else if (upd_en)   q <= cells;
  end
endmodule

// File: rtl/jsel_tdo_stage.sv
// Falling-edge output register for TDO and its enable.
module jsel_tdo_stage (
  input  logic tck,
  input  logic trst_n,
  input  logic drive_en,
  input  logic d,
  output logic tdo,
  output logic tdo_en
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= drive_en;
      if (drive_en) tdo <= d;
    end
  end
endmodule

// File: rtl/jtag_chain_sel.sv
module jtag_chain_sel #(
  parameter int          DBUS_W      = 32,
  parameter int          ABUS_W      = 32,
  parameter int          CTRL_W      = 4,
  parameter int          C0_DATA_W   = 4,
  parameter int          CHAIN_W     = 4,
  parameter int          RESET_CHAIN = 3,
  parameter logic [31:0] ID_CODE     = 32'h15A7_0C01
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic [3:0]        tap_state,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic [DBUS_W-1:0] core_dbus_in,
  input  logic [ABUS_W-1:0] core_abus_in,
  input  logic [CTRL_W-1:0] core_ctrl_in,
  output logic [C0_DATA_W-1:0] ch0_dbus_out,
  output logic [CTRL_W-1:0] ch0_ctrl_out,
  output logic [ABUS_W-1:0] ch0_abus_out,
  output logic [DBUS_W-1:0] ch1_dbus_out,
  output logic              core_clk_hold,
  output logic              ext_si,
  input  logic [1:0]        ext_so,
  output logic [1:0]        ext_sel,
  output logic              ext_capture,
  output logic              ext_shift,
  output logic              ext_update
);
  import jsel_pkg::*;

  localparam int C0_CTRL_LO = C0_DATA_W;
  localparam int C0_ADDR_LO = C0_DATA_W + CTRL_W;
  localparam int C0_LEN     = C0_ADDR_LO + ABUS_W;

  tap_state_e st;
  assign st = tap_state_e'(tap_state);

  logic in_tlr, in_cdr, in_sdr, in_udr, in_cir, in_sir, in_uir;
  assign in_tlr = (st == TS_TLR);
  assign in_cdr = (st == TS_CAPDR);
  assign in_sdr = (st == TS_SHDR);
  assign in_udr = (st == TS_UPDDR);
  assign in_cir = (st == TS_CAPIR);
  assign in_sir = (st == TS_SHIR);
  assign in_uir = (st == TS_UPDIR);

  logic [IR_W-1:0]    ir_q;
  logic               ir_so;
  logic [CHAIN_W-1:0] chain_q;
  logic               num_so;
  dr_path_e           path;

  jsel_shadowed_reg #(
    .W(IR_W), .RST_VAL(OP_IDCODE), .CAP_CONST(1'b1), .CAP_VAL(IR_CAPTURE)
  ) u_ir (
    .tck(tck), .trst_n(trst_n), .sync_rst(in_tlr),
    .cap_en(in_cir), .shift_en(in_sir), .upd_en(in_uir),
    .si(tdi), .q(ir_q), .so(ir_so)
  );

  jsel_shadowed_reg #(
    .W(CHAIN_W), .RST_VAL(CHAIN_W'(RESET_CHAIN)), .CAP_CONST(1'b0), .CAP_VAL('0)
  ) u_chain_num (
    .tck(tck), .trst_n(trst_n), .sync_rst(in_tlr),
    .cap_en(in_cdr && path == P_SELECT),
    .shift_en(in_sdr && path == P_SELECT),
    .upd_en(in_udr && path == P_SELECT),
    .si(tdi), .q(chain_q), .so(num_so)
  );

  // instruction and chain number to data path
  always_comb begin
    unique case (ir_q)
      OP_ACCESS: begin
        if (chain_q == CHAIN_W'(0))      path = P_CH0;
        else if (chain_q == CHAIN_W'(1)) path = P_CH1;
        else if (chain_q == CHAIN_W'(2) || chain_q == CHAIN_W'(3)) path = P_EXT;
        else                             path = P_BYPASS;
      end
      OP_SELECT: path = P_SELECT;
      OP_IDCODE: path = P_IDCODE;
      default:   path = P_BYPASS;
    endcase
  end

  // bypass and identification registers
  logic        byp_q;
  logic [31:0] id_sh;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_sh <= '0;
    end else if (in_cdr) begin
      byp_q <= 1'b0;
      id_sh <= ID_CODE;
    end else if (in_sdr) begin
      byp_q <= tdi;
      id_sh <= {tdi, id_sh[31:1]};
    end
  end

  // chain 0: data, control, address (reversed)
  logic [C0_LEN-1:0] c0_cap, c0_cells;
  always_comb begin
    c0_cap[C0_DATA_W-1:0]           = core_dbus_in[C0_DATA_W-1:0];
    c0_cap[C0_ADDR_LO-1:C0_CTRL_LO] = core_ctrl_in;
    for (int k = 0; k < ABUS_W; k++) c0_cap[C0_ADDR_LO+k] = core_abus_in[ABUS_W-1-k];
  end

  jsel_scan_chain #(.LEN(C0_LEN), .OUT_AT_LSB(1'b0)) u_chain0 (
    .tck(tck), .trst_n(trst_n),
    .cap_en(in_cdr && path == P_CH0), .shift_en(in_sdr && path == P_CH0),
    .si(tdi), .cap_val(c0_cap), .cells(c0_cells)
  );

  assign ch0_dbus_out = c0_cells[C0_DATA_W-1:0];
  assign ch0_ctrl_out = c0_cells[C0_ADDR_LO-1:C0_CTRL_LO];
  generate
    for (genvar k = 0; k < ABUS_W; k++) begin : g_c0_addr
      assign ch0_abus_out[ABUS_W-1-k] = c0_cells[C0_ADDR_LO+k];
    end
  endgenerate

  // chain 1: data bus, bit 0 nearest TDI
  jsel_scan_chain #(.LEN(DBUS_W), .OUT_AT_LSB(1'b0)) u_chain1 (
    .tck(tck), .trst_n(trst_n),
    .cap_en(in_cdr && path == P_CH1), .shift_en(in_sdr && path == P_CH1),
    .si(tdi), .cap_val(core_dbus_in), .cells(ch1_dbus_out)
  );

  // external chains 2 and 3
  assign ext_si      = tdi;
  assign ext_sel     = {path == P_EXT && chain_q[0], path == P_EXT && !chain_q[0]};
  assign ext_capture = in_cdr && path == P_EXT;
  assign ext_shift   = in_sdr && path == P_EXT;
  assign ext_update  = in_udr && path == P_EXT;

  assign core_clk_hold = (chain_q == CHAIN_W'(0)) || (chain_q == CHAIN_W'(1));

  logic dr_so;
  always_comb begin
    unique case (path)
      P_IDCODE: dr_so = id_sh[0];
      P_SELECT: dr_so = num_so;
      P_CH0:    dr_so = c0_cells[C0_LEN-1];
      P_CH1:    dr_so = ch1_dbus_out[DBUS_W-1];
      P_EXT:    dr_so = ext_so[chain_q[0]];
      default:  dr_so = byp_q;
    endcase
  end

  jsel_tdo_stage u_tdo (
    .tck(tck), .trst_n(trst_n),
    .drive_en(in_sdr || in_sir),
    .d(in_sir ? ir_so : dr_so),
    .tdo(tdo), .tdo_en(tdo_en)
  );
endmodule

// File: rtl/jtag_chain_sel_chk.sv
module jtag_chain_sel_chk #(
  parameter int DBUS_W = 32,
  parameter int ABUS_W = 32
) (
  input logic              tck,
  input logic              trst_n,
  input logic [3:0]        tap_state,
  input logic              tdo_en,
  input logic              core_clk_hold,
  input logic [1:0]        ext_sel,
  input logic              ext_capture,
  input logic              ext_shift,
  input logic [DBUS_W-1:0] ch1_dbus_out,
  input logic [ABUS_W-1:0] ch0_abus_out
);
  import jsel_pkg::*;

  // R8
  tdo_en_scope_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (tap_state == TS_SHDR || tap_state == TS_SHIR));

  // R6
  ext_sel_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(ext_sel));

  // R7
  hold_vs_ext_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ext_sel != 2'b00) |-> !core_clk_hold);

  // R6
  ext_strobe_sel_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ext_shift || ext_capture) |-> (ext_sel != 2'b00));

  // R4
  ch1_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(tap_state == TS_CAPDR || tap_state == TS_SHDR) |=> $stable(ch1_dbus_out));

  // R5
  ch0_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(tap_state == TS_CAPDR || tap_state == TS_SHDR) |=> $stable(ch0_abus_out));
endmodule

bind jtag_chain_sel jtag_chain_sel_chk #(.DBUS_W(DBUS_W), .ABUS_W(ABUS_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .tap_state(tap_state), .tdo_en(tdo_en),
  .core_clk_hold(core_clk_hold), .ext_sel(ext_sel), .ext_capture(ext_capture),
  .ext_shift(ext_shift), .ch1_dbus_out(ch1_dbus_out), .ch0_abus_out(ch0_abus_out)
);

// File: tb/jtag_chain_sel_test.sv
`timescale 1ns/1ps
module jtag_chain_sel_test;
  import jsel_pkg::*;

  localparam logic [31:0] ID = 32'h2B3C_4D5F;

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic [3:0]  tap_state = 4'hF;
  logic        tdi = 1'b0;
  logic        tdo, tdo_en;
  logic [31:0] core_dbus_in = '0;
  logic [31:0] core_abus_in = '0;
  logic [3:0]  core_ctrl_in = '0;
  logic [3:0]  ch0_dbus_out, ch0_ctrl_out;
  logic [31:0] ch0_abus_out, ch1_dbus_out;
  logic        core_clk_hold, ext_si, ext_capture, ext_shift, ext_update;
  logic [1:0]  ext_so = 2'b00;
  logic [1:0]  ext_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 tck = ~tck;   // 125 MHz

  jtag_chain_sel #(.ID_CODE(ID)) uut (
    .tck(tck), .trst_n(trst_n), .tap_state(tap_state), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en),
    .core_dbus_in(core_dbus_in), .core_abus_in(core_abus_in), .core_ctrl_in(core_ctrl_in),
    .ch0_dbus_out(ch0_dbus_out), .ch0_ctrl_out(ch0_ctrl_out), .ch0_abus_out(ch0_abus_out),
    .ch1_dbus_out(ch1_dbus_out), .core_clk_hold(core_clk_hold),
    .ext_si(ext_si), .ext_so(ext_so), .ext_sel(ext_sel),
    .ext_capture(ext_capture), .ext_shift(ext_shift), .ext_update(ext_update)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // drive one TAP state just after the rising edge
  task automatic tick(input logic [3:0] s, input logic d);
    @(posedge tck);
    #1;
    tap_state = s;
    tdi = d;
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] got);
    got = '0;
    tick(TS_CAPIR, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick(TS_SHIR, op[i]);
      #5 got[i] = tdo;
    end
    tick(TS_EX1IR, 1'b0);
    tick(TS_UPDIR, 1'b0);
    tick(TS_RTI, 1'b0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input bit upd, output logic [63:0] dout);
    dout = '0;
    tick(TS_CAPDR, 1'b0);
    for (int i = 0; i < n; i++) begin
      tick(TS_SHDR, din[i]);
      #5 dout[i] = tdo;
    end
    tick(TS_EX1DR, 1'b0);
    tick(upd ? TS_UPDDR : TS_PAUSEDR, 1'b0);
    tick(TS_RTI, 1'b0);
  endtask

  task automatic select_chain(input logic [3:0] num);
    logic [3:0]  g;
    logic [63:0] d;
    scan_ir(OP_SELECT, g);
    scan_dr(4, {60'd0, num}, 1'b1, d);
  endtask

  task automatic t_reset;
    #5;
    eq("R8 tdo_en after reset", tdo_en, 0);
    eq("R7 hold after reset (chain 3)", core_clk_hold, 0);
    eq("R6 ext_sel after reset", ext_sel, 0);
  endtask

  task automatic t_idcode;
    logic [63:0] d;
    scan_dr(32, 64'h0, 1'b1, d);
    eq("R1 IDCODE after reset", d[31:0], ID);
  endtask

  task automatic t_ir_capture_bypass;
    logic [3:0]  g;
    logic [63:0] d;
    scan_ir(OP_BYPASS, g);
    eq("R1 IR capture pattern", g, 4'b0001);
    scan_dr(4, 64'b1011, 1'b1, d);
    eq("R2 bypass one-bit delay", d[3:0], 4'b0110);
  endtask

  task automatic t_unsupported;
    logic [3:0]  g;
    logic [63:0] d;
    scan_ir(4'hC, g);
    scan_dr(6, 64'b110101, 1'b1, d);
    eq("R9 INTEST opcode -> bypass", d[5:0], 6'b101010);
    scan_ir(4'h4, g);
    scan_dr(4, 64'b0011, 1'b1, d);
    eq("R9 RUNBIST opcode -> bypass", d[3:0], 4'b0110);
    scan_ir(4'h8, g);
    scan_dr(4, 64'b1001, 1'b1, d);
    eq("R9 USERCODE opcode -> bypass", d[3:0], 4'b0010);
  endtask

  task automatic t_select_timing;
    logic [3:0]  g;
    logic [63:0] d;
    scan_ir(OP_SELECT, g);
    scan_dr(4, 64'd1, 1'b0, d);
    eq("R3 readback of reset chain number", d[3:0], 4'd3);
    eq("R3 no effect before Update-DR", core_clk_hold, 0);
    scan_dr(4, 64'd1, 1'b1, d);
    eq("R3 readback still 3", d[3:0], 4'd3);
    eq("R7 hold with chain 1", core_clk_hold, 1);
    scan_dr(4, 64'd1, 1'b1, d);
    eq("R3 readback after update", d[3:0], 4'd1);
  endtask

  task automatic t_chain1;
    logic [3:0]  g;
    logic [63:0] d;
    logic [31:0] cap, din, exp_out, exp_cells;
    select_chain(4'd1);
    scan_ir(OP_ACCESS, g);
    cap = 32'hA5C3_0F96;
    din = 32'h1234_5678;
    core_dbus_in = cap;
    scan_dr(32, {32'd0, din}, 1'b1, d);
    for (int i = 0; i < 32; i++) begin
      exp_out[i] = cap[31-i];
      exp_cells[31-i] = din[i];
    end
    eq("R4 chain1 capture, bit 31 first", d[31:0], exp_out);
    eq("R4 chain1 parallel out", ch1_dbus_out, exp_cells);
    cap = 32'h0000_FFFF;
    core_dbus_in = cap;
    scan_dr(8, 64'hC3, 1'b0, d);
    for (int j = 0; j < 32; j++) exp_cells[j] = (j < 8) ? d[0] ^ d[0] ^ (8'hC3 >> (7 - j)) & 1'b1 : cap[j-8];
    eq("R4 chain1 follows shift without update", ch1_dbus_out, exp_cells);
  endtask

  task automatic t_chain0;
    logic [3:0]  g;
    logic [63:0] d;
    logic [39:0] cap, din, nc, exp_out;
    logic [31:0] exp_a;
    core_dbus_in = 32'h0000_0009;
    core_ctrl_in = 4'h6;
    core_abus_in = 32'hC000_0005;
    select_chain(4'd0);
    eq("R7 hold with chain 0", core_clk_hold, 1);
    scan_ir(OP_ACCESS, g);
    for (int j = 0; j < 4; j++) cap[j] = core_dbus_in[j];
    for (int j = 0; j < 4; j++) cap[4+j] = core_ctrl_in[j];
    for (int j = 0; j < 32; j++) cap[8+j] = core_abus_in[31-j];
    din = 40'h5A_F0E1_D2C3;
    scan_dr(40, {24'd0, din}, 1'b1, d);
    for (int i = 0; i < 40; i++) begin
      exp_out[i] = cap[39-i];
      nc[39-i] = din[i];
    end
    eq("R5 chain0 first bit is address 0", d[0], core_abus_in[0]);
    eq("R5 chain0 captured order", d[39:0], exp_out);
    for (int k = 0; k < 32; k++) exp_a[31-k] = nc[8+k];
    eq("R5 chain0 data cells", ch0_dbus_out, nc[3:0]);
    eq("R5 chain0 control cells", ch0_ctrl_out, nc[7:4]);
    eq("R5 chain0 address cells", ch0_abus_out, exp_a);
  endtask

  task automatic t_external;
    logic [3:0]  g;
    logic [63:0] d;
    ext_so = 2'b01;
    select_chain(4'd2);
    eq("R6 ext_sel chain 2", ext_sel, 2'b00);
    scan_ir(OP_ACCESS, g);
    eq("R6 ext_sel chain 2 under access", ext_sel, 2'b01);
    eq("R7 no hold for chain 2", core_clk_hold, 0);
    tick(TS_CAPDR, 1'b0);
    #5 eq("R6 ext_capture strobe", ext_capture, 1);
    tick(TS_SHDR, 1'b1);
    #5 eq("R6 chain2 return on tdo", tdo, 1);
    eq("R6 ext_shift strobe", ext_shift, 1);
    eq("R6 ext_si follows tdi", ext_si, 1);
    eq("R8 tdo_en in Shift-DR", tdo_en, 1);
    tick(TS_EX1DR, 1'b0);
    #5 eq("R8 tdo_en off in Exit1-DR", tdo_en, 0);
    tick(TS_UPDDR, 1'b0);
    #5 eq("R6 ext_update strobe", ext_update, 1);
    tick(TS_RTI, 1'b0);
    select_chain(4'd3);
    scan_ir(OP_ACCESS, g);
    eq("R6 ext_sel chain 3", ext_sel, 2'b10);
    scan_dr(1, 64'd0, 1'b1, d);
    eq("R6 chain3 return on tdo", d[0], 0);
  endtask

  task automatic t_out_of_range;
    logic [3:0]  g;
    logic [63:0] d;
    select_chain(4'd9);
    scan_dr(4, 64'd9, 1'b1, d);
    eq("R10 chain number 9 read back", d[3:0], 4'd9);
    scan_ir(OP_ACCESS, g);
    eq("R10 no ext_sel for chain 9", ext_sel, 2'b00);
    eq("R10 no hold for chain 9", core_clk_hold, 0);
    scan_dr(4, 64'b1011, 1'b1, d);
    eq("R10 chain 9 access is bypass", d[3:0], 4'b0110);
  endtask

  task automatic t_tlr;
    logic [3:0]  g;
    logic [63:0] d;
    select_chain(4'd1);
    scan_ir(OP_BYPASS, g);
    eq("R11 hold before reset state", core_clk_hold, 1);
    tick(TS_TLR, 1'b0);
    tick(TS_RTI, 1'b0);
    #5 eq("R11 chain number back to 3", core_clk_hold, 0);
    scan_dr(32, 64'h0, 1'b1, d);
    eq("R11 IR back to IDCODE", d[31:0], ID);
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #1 trst_n = 1'b1;
    tap_state = TS_RTI;
    t_reset();
    t_idcode();
    t_ir_capture_bypass();
    t_unsupported();
    t_select_timing();
    t_chain1();
    t_chain0();
    t_external();
    t_out_of_range();
    t_tlr();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog: got %0d cycles expected completion", 200000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule